// File: doc/BRIEF.md
# Oscillator Settling Progress Monitor

This block runs on the clock of an external crystal oscillator and measures how long that oscillator has been running since it was last restarted. A 17-bit counter advances once per oscillator cycle. Five power-of-two milestones (2^11, 2^13, 2^14, 2^15 and 2^16 cycles) are recorded in a sticky status byte. The byte fills like a thermometer, so software polling it can see how far the oscillator has progressed toward a stable state.

A 3-bit select input picks which milestone counts as "settled". The counter stops at that milestone, so no status bit for a longer milestone can ever be set. A done flag tells the clock controller that the selected milestone has been reached. A synchronous clear input restarts the measurement. It is raised on reset release, on entry into the low-power stop state, and when the oscillator is switched off. The status can be read as a whole byte, or one bit at a time through a bit-select read port.

Top module: `osc_stab_monitor`

## Requirements
- R1: While the asynchronous reset is asserted, the status byte reads 00H and the done flag is 0.
- R2: A clear request sampled high at a clock edge leaves the status byte at 00H, the done flag at 0 and the counter at zero after that edge, whatever the earlier state.
- R3: When a clear request arrives in a cycle in which the counter would advance, the clear takes effect. Counting restarts from zero, so the first milestone is then reached 2048 edges after that clear edge.
- R4: The milestone bits sit at fixed positions: bit 4 for 2^11 cycles, bit 3 for 2^13, bit 2 for 2^14, bit 1 for 2^15 and bit 0 for 2^16. Each bit becomes 1 at exactly the clock edge that completes that many cycles after the clear edge, and not one edge earlier.
- R5: The status byte only ever holds one of 00H, 10H, 18H, 1CH, 1EH or 1FH.
- R6: Once a status bit is 1, it stays 1 until the next clear request, including when the select input changes.
- R7: Counting stops at the selected milestone. Bits for longer milestones stay 0. If the select input is raised later, counting resumes from the held value.
- R8: Select codes 0, 1, 2, 3 and 4 choose the 2^11, 2^13, 2^14, 2^15 and 2^16 milestones. Codes 5, 6 and 7 choose 2^16.
- R9: The done flag is 1 exactly when the status bit of the currently selected milestone is 1. It therefore rises on the same edge as that bit.
- R10: Bits 7 to 5 of the status byte always read 0.
- R11: The single-bit read output equals the status byte bit whose index (0 to 7) is given on the bit-select input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock being measured |
| arst_osc_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_req | input | 1 | Synchronous clear of counter and status |
| thr_sel | input | 3 | Milestone select code |
| bit_sel | input | 3 | Index of the status bit shown on stat_bit |
| stab_done | output | 1 | Selected milestone reached |
| stat_byte | output | 8 | Thermometer status byte |
| stat_bit | output | 1 | Single status bit chosen by bit_sel |

## Verification
A clear request and a counter increment can fall in the same cycle. The bench provokes this by raising the clear 1000 cycles into a run, while the counter is still advancing. The clear must win: the status must read 00H on the next edge, and the first milestone must appear 2048 edges after the second clear, not after the first one. The rise of a milestone bit and the rise of the done flag also share a cycle. The scoreboard compares both at the edge before and the edge of every milestone, for each select code it runs.

// File: rtl/osc_stab_pkg.sv
`timescale 1ns/1ps
package osc_stab_pkg;

  // milestone ladder: first exponent, then one gap of two, then steps of one
  localparam int NUM_THR  = 5;
  localparam int BASE_EXP = 11;
  localparam int TOP_EXP  = BASE_EXP + NUM_THR;
  localparam int CNT_W    = TOP_EXP + 1;
  localparam int SEL_W    = 3;
  localparam int IDX_W    = $clog2(NUM_THR);
  localparam int STAT_W   = 8;

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [NUM_THR-1:0] thr_vec_t;
  typedef logic [IDX_W-1:0]   thr_idx_t;

  function automatic int thr_exp(input int idx);
    return (idx == 0) ? BASE_EXP : BASE_EXP + 1 + idx;
  endfunction

  function automatic cnt_t thr_count(input int idx);
    cnt_t v;
    v = '0;
    v[thr_exp(idx)] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/osc_stab_rst_sync.sv
`timescale 1ns/1ps
module osc_stab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/osc_stab_limit.sv
`timescale 1ns/1ps
module osc_stab_limit
  import osc_stab_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic [SW-1:0] sel,
  output thr_idx_t      idx,
  output cnt_t          limit
);

  // codes above the last milestone fold onto the longest one
  always_comb begin
    if (sel >= SW'(NUM_THR - 1)) begin
      idx = thr_idx_t'(NUM_THR - 1);
    end else begin
      idx = thr_idx_t'(sel);
    end
  end

  always_comb begin
    limit = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      if (idx == thr_idx_t'(i)) begin
        limit = thr_count(i);
      end
    end
  end

endmodule

// File: rtl/osc_stab_cnt.sv
`timescale 1ns/1ps
module osc_stab_cnt
  import osc_stab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  cnt_t limit,
  output cnt_t cnt_q,
  output cnt_t cnt_nxt
);

  logic below;
  logic cnt_en;

  assign below  = (cnt_q < limit);
  assign cnt_en = clr | below;

  always_comb begin
    if (clr) begin
      cnt_nxt = '0;
    end else if (below) begin
      cnt_nxt = cnt_q + cnt_t'(1);
    end else begin
      cnt_nxt = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= thr_count(NUM_THR - 1)); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R3

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (cnt_q >= limit)) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/osc_stab_therm.sv
`timescale 1ns/1ps
module osc_stab_therm
  import osc_stab_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  cnt_t     cnt_nxt,
  output thr_vec_t stat_q
);

  thr_vec_t hit;
  thr_vec_t stat_nxt;
  logic     stat_en;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_hit
    assign hit[g] = (cnt_nxt == thr_count(g));
  end

  assign stat_en = clr | (|(hit & ~stat_q));

  always_comb begin
    if (clr) begin
      stat_nxt = '0;
    end else begin
      stat_nxt = stat_q | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_nxt;
    end
  end

  AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_vec_t'(stat_q + 1'b1) & stat_q) == '0); // R5

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stat_q == '0)); // R2

  for (genvar g = 0; g < NUM_THR; g++) begin : g_sticky
    AST_BIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && stat_q[g]) |=> stat_q[g]); // R6
  end

endmodule

// File: rtl/osc_stab_monitor.sv
`timescale 1ns/1ps
module osc_stab_monitor
  import osc_stab_pkg::*;
(
  input  logic              clk_osc,
  input  logic              arst_osc_n,
  input  logic              clr_req,
  input  logic [SEL_W-1:0]  thr_sel,
  input  logic [2:0]        bit_sel,
  output logic              stab_done,
  output logic [STAT_W-1:0] stat_byte,
  output logic              stat_bit
);

  logic     rst_n;
  thr_idx_t sel_idx;
  cnt_t     limit;
  cnt_t     cnt_q;
  cnt_t     cnt_nxt;
  thr_vec_t stat_q;

  osc_stab_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk_osc),
    .arst_n (arst_osc_n),
    .rst_n  (rst_n)
  );

  osc_stab_limit #(.SW(SEL_W)) i_limit (
    .sel   (thr_sel),
    .idx   (sel_idx),
    .limit (limit)
  );

  osc_stab_cnt i_cnt (
    .clk     (clk_osc),
    .rst_n   (rst_n),
    .clr     (clr_req),
    .limit   (limit),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  osc_stab_therm i_therm (
    .clk     (clk_osc),
    .rst_n   (rst_n),
    .clr     (clr_req),
    .cnt_nxt (cnt_nxt),
    .stat_q  (stat_q)
  );

  // shortest milestone lands on the highest used bit
  for (genvar g = 0; g < NUM_THR; g++) begin : g_map
    assign stat_byte[NUM_THR-1-g] = stat_q[g];
  end
  assign stat_byte[STAT_W-1:NUM_THR] = '0;

  assign stab_done = stat_q[sel_idx];
  assign stat_bit  = stat_byte[bit_sel];

  AST_DONE_REACHED: assert property (@(posedge clk_osc) disable iff (!rst_n)
    stab_done |-> (cnt_q >= limit)); // R9

  AST_DONE_NEEDS_BYTE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    stab_done |-> (stat_byte != '0)); // R9

endmodule

// File: tb/test_osc_stab_monitor.sv
`timescale 1ns/1ps
module test_osc_stab_monitor;

  typedef struct {
    int         at;
    logic [7:0] stat;
    logic       done;
    string      tag;
  } exp_t;

  logic       clk_osc = 1'b0;
  logic       arst_osc_n;
  logic       clr_req;
  logic [2:0] thr_sel;
  logic [2:0] bit_sel;
  logic       stab_done;
  logic [7:0] stat_byte;
  logic       stat_bit;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  int   pc = 0;
  exp_t q[$];

  always #2.5 clk_osc = ~clk_osc;
  always @(posedge clk_osc) cyc = cyc + 1;

  osc_stab_monitor i_osc_stab_monitor (
    .clk_osc    (clk_osc),
    .arst_osc_n (arst_osc_n),
    .clr_req    (clr_req),
    .thr_sel    (thr_sel),
    .bit_sel    (bit_sel),
    .stab_done  (stab_done),
    .stat_byte  (stat_byte),
    .stat_bit   (stat_bit)
  );

  function automatic logic [7:0] therm(input int n);
    logic [7:0] v;
    v = '0;
    for (int b = 0; b < n; b++) v[4-b] = 1'b1;
    return v;
  endfunction

  function automatic int thr(input int j);
    return (j == 0) ? 2048 : (1 << (12 + j));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int at, input logic [7:0] s, input logic d, input string tag);
    exp_t e;
    e.at = at; e.stat = s; e.done = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk_osc);
  endtask

  task automatic do_clear();
    @(negedge clk_osc);
    clr_req = 1'b1;
    pc = cyc + 1;
    @(negedge clk_osc);
    clr_req = 1'b0;
    check(stat_byte == 8'h00, "R2 status after clear", stat_byte, 0);
    check(stab_done == 1'b0, "R2 done after clear", stab_done, 0);
  endtask

  // R4 R8 R9: edge before and edge of every milestone up to the selected one
  task automatic run_sel(input int code);
    int k;
    @(negedge clk_osc);
    thr_sel = 3'(code);
    do_clear();
    k = (code > 4) ? 4 : code;
    for (int j = 0; j <= k; j++) begin
      push(pc + thr(j) - 1, therm(j), 1'b0, "R4 before milestone");
      push(pc + thr(j), therm(j + 1), (j == k), "R4 R9 at milestone");
    end
    push(pc + thr(k) + 40, therm(k + 1), 1'b1, "R7 held after milestone");
    drain();
  endtask

  task automatic sweep_bits(input logic [7:0] exp_b);
    for (int b = 0; b < 8; b++) begin
      bit_sel = 3'(b);
      #1;
      check(stat_bit == exp_b[b], "R11 bit read", stat_bit, exp_b[b]);
    end
  endtask

  // monitor: legality every cycle, scoreboard items at their cycle
  always @(negedge clk_osc) begin
    if (arst_osc_n) begin
      check(stat_byte inside {8'h00, 8'h10, 8'h18, 8'h1C, 8'h1E, 8'h1F},
            "R5 R10 legal pattern", stat_byte, 0);
      while (q.size() != 0 && q[0].at <= cyc) begin
        if (q[0].at < cyc) begin
          check(1'b0, {q[0].tag, " missed"}, q[0].at, cyc);
        end else begin
          check(stat_byte == q[0].stat, q[0].tag, stat_byte, q[0].stat);
          check(stab_done == q[0].done, {q[0].tag, " done"}, stab_done, q[0].done);
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk_osc);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0;
    arst_osc_n = 1'b0;
    clr_req = 1'b0;
    thr_sel = 3'd0;
    bit_sel = 3'd0;
    repeat (3) @(negedge clk_osc);
    check(stat_byte == 8'h00, "R1 reset status", stat_byte, 0);
    check(stab_done == 1'b0, "R1 reset done", stab_done, 0);
    check(stat_bit == 1'b0, "R1 reset bit read", stat_bit, 0);
    arst_osc_n = 1'b1;
    repeat (4) @(negedge clk_osc);

    // R3: clear while counter is advancing
    thr_sel = 3'd0;
    do_clear();
    repeat (1000) @(negedge clk_osc);
    do_clear();
    push(pc + 2047, 8'h00, 1'b0, "R3 restart before");
    push(pc + 2048, 8'h10, 1'b1, "R3 restart at");
    drain();

    run_sel(0);

    // R6 R7: raise select after saturation, counting resumes, bit stays
    @(negedge clk_osc);
    thr_sel = 3'd1;
    c0 = cyc;
    push(c0 + 6143, 8'h10, 1'b0, "R6 sticky during resume");
    push(c0 + 6144, 8'h18, 1'b1, "R7 resume reaches next");
    drain();
    sweep_bits(8'h18);

    run_sel(1);
    run_sel(2);
    run_sel(3);

    // R8: code 6 must not stop at 2^15
    @(negedge clk_osc);
    thr_sel = 3'd6;
    do_clear();
    push(pc + 32767, 8'h1C, 1'b0, "R8 code6 before 2^15");
    push(pc + 32768, 8'h1E, 1'b0, "R8 code6 past 2^15");
    push(pc + 32800, 8'h1E, 1'b0, "R8 code6 keeps counting");
    drain();

    run_sel(4);
    sweep_bits(8'h1F);
    for (int s = 5; s < 8; s++) begin
      thr_sel = 3'(s);
      #1;
      check(stab_done == 1'b1, "R8 high code maps to 2^16", stab_done, 1);
    end
    thr_sel = 3'd3;
    #1;
    check(stab_done == 1'b1, "R9 done follows selected bit", stab_done, 1);

    // R2: clear from a fully settled state
    do_clear();
    sweep_bits(8'h00);
    repeat (3) @(negedge clk_osc);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule